// File: doc/BRIEF.md
# Serial Port with Masked Address Recognition

This block is a byte-oriented asynchronous serial port with a small synchronous register port. One register address serves two storage elements. A write there loads the transmitter and starts a frame. A read there returns the last byte the receiver accepted. Two more registers hold the node's own address and a per-bit compare mask.

Each frame carries a start bit, eight data bits (least significant first), a ninth bit and a stop bit. Every bit lasts a fixed number of baud ticks; the tick comes from outside. The receiver samples the line at the tick rate and decides each bit by a vote of three samples near the bit centre. Multiprocessor mode lets several nodes share one line. A frame whose ninth bit is 1 carries an address, and the node selects itself when every address bit enabled by the mask equals its stored address. While the node is not selected, it drops the data frames that follow.

Top module: `uart_maddr`

## Requirements
- R1: After reset, the data, address and mask registers read 0x00, `txd` is 1, and `tx_done`, `rx_ready`, `rx_ninth` and `addr_match` are 0.
- R2: `reg_addr` 0 is the data register, 1 the own-address register and 2 the compare-mask register. Reads are combinational. Address 3 reads 0x00. Reading address 0 returns the receive latch, never the byte last written.
- R3: Writing address 0 while idle starts a frame on `txd`. The frame is a start bit of 0, data bits 0 to 7, the ninth bit taken from `tx_ninth` at the write, and a stop bit of 1. The start bit appears in the cycle after the write, and each bit lasts 16 baud ticks.
- R4: A write to address 0 while a frame is being sent has no effect on that frame.
- R5: `tx_done` becomes 1 when the stop bit ends. It stays 1 until `clr_tx_done` is pulsed. A set in the same cycle as a clear wins.
- R6: Each received bit is the majority of three consecutive tick samples near its centre, so a one-sample flip inside a bit is corrected.
- R7: A falling edge whose start bit is not low at mid-bit is discarded. No byte is latched, and the receiver is ready for the next real start bit.
- R8: A byte reaches the receive latch only if its stop bit is 1. A frame with a 0 stop bit leaves the latch, `rx_ready` and `rx_ninth` unchanged.
- R9: An accepted frame sets `rx_ready` and copies its ninth bit to `rx_ninth`. `rx_ready` stays 1 until `clr_rx_ready` is pulsed.
- R10: With `mp_mode` 0, every frame with a valid stop bit is accepted, whatever its ninth bit.
- R11: With `mp_mode` 1, a frame whose ninth bit is 1 is an address. If ((byte ^ own address) & mask) == 0, it sets `addr_match` and is latched. Otherwise it clears `addr_match` and is not latched.
- R12: With `mp_mode` 1, a frame whose ninth bit is 0 is accepted only while `addr_match` is 1.
- R13: With the mask at 0x00, every address frame matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | Oversampling tick, 16 per bit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| tx_ninth | input | 1 | Ninth bit for the next transmitted frame |
| mp_mode | input | 1 | Multiprocessor address filtering enable |
| clr_tx_done | input | 1 | Clears `tx_done` |
| clr_rx_ready | input | 1 | Clears `rx_ready` |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, idle high |
| tx_done | output | 1 | Frame sent |
| rx_ready | output | 1 | Byte accepted into the receive latch |
| rx_ninth | output | 1 | Ninth bit of the latched frame |
| addr_match | output | 1 | Node selected by the last address frame |

## Verification
The assertions assume three things about the inputs. `mp_mode` and the mask stay constant while a frame is in flight. `rxd` changes no faster than once per baud tick outside deliberate glitches. The flag-clear inputs are one-cycle pulses. The bench holds `baud_tick` high, so one bit lasts 16 clocks. It changes `mp_mode` and the registers only between frames. It drives `rxd` either from `txd` in loopback or in whole 16-cycle bit slots, and the only extra edges are the single-cycle flip and the short start pulse that it injects on purpose.

// File: rtl/uart_maddr.sv
module uart_maddr #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       tx_ninth,
  input  logic       mp_mode,
  input  logic       clr_tx_done,
  input  logic       clr_rx_ready,
  input  logic       rxd,
  output logic       txd,
  output logic       tx_done,
  output logic       rx_ready,
  output logic       rx_ninth,
  output logic       addr_match
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] C_LAST = CW'(OSR - 1);
  localparam logic [CW-1:0] C_S0   = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] C_S1   = CW'(OSR / 2);
  localparam logic [CW-1:0] C_S2   = CW'(OSR / 2 + 1);
  localparam logic [3:0]    LASTB  = 4'd10;

  logic [7:0] own_addr, cmp_mask, rbuf;

  wire wr_data = reg_wr && reg_addr == 2'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_addr <= '0;
      cmp_mask <= '0;
    end else if (reg_wr) begin
      if (reg_addr == 2'd1) own_addr <= reg_wdata;
      if (reg_addr == 2'd2) cmp_mask <= reg_wdata;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = rbuf;
      2'd1:    reg_rdata = own_addr;
      2'd2:    reg_rdata = cmp_mask;
      default: reg_rdata = 8'h00;
    endcase
  end

  // transmitter
  logic          tx_busy;
  logic [10:0]   tx_sh;
  logic [CW-1:0] tx_cnt;
  logic [3:0]    tx_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_sh   <= '1;
      tx_cnt  <= '0;
      tx_bit  <= '0;
      tx_done <= 1'b0;
    end else begin
      if (clr_tx_done) tx_done <= 1'b0;
      if (!tx_busy) begin
        if (wr_data) begin
          tx_busy <= 1'b1;
          tx_sh   <= {1'b1, tx_ninth, reg_wdata, 1'b0};
          tx_cnt  <= '0;
          tx_bit  <= '0;
        end
      end else if (baud_tick) begin
        tx_cnt <= tx_cnt + 1'b1;
        if (tx_cnt == C_LAST) begin
          tx_cnt <= '0;
          tx_sh  <= {1'b1, tx_sh[10:1]};
          if (tx_bit == LASTB) begin
            tx_busy <= 1'b0;
            tx_done <= 1'b1;
          end else begin
            tx_bit <= tx_bit + 1'b1;
          end
        end
      end
    end
  end

  assign txd = tx_busy ? tx_sh[0] : 1'b1;

  // receiver
  logic          rx_m, rx_s, rx_act;
  logic [CW-1:0] rx_cnt;
  logic [3:0]    rx_bit;
  logic [1:0]    rx_smp;
  logic [8:0]    rx_sh;

  wire vote     = (rx_smp[0] & rx_smp[1]) | (rx_smp[0] & rx_s) | (rx_smp[1] & rx_s);
  wire decide   = rx_act && baud_tick && rx_cnt == C_S2;
  wire stop_ok  = decide && rx_bit == LASTB && vote;
  wire addr_hit = ((rx_sh[7:0] ^ own_addr) & cmp_mask) == 8'h00;
  wire accept   = stop_ok && (!mp_mode || (rx_sh[8] ? addr_hit : addr_match));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_m   <= 1'b1;
      rx_s   <= 1'b1;
      rx_act <= 1'b0;
      rx_cnt <= '0;
      rx_bit <= '0;
      rx_smp <= '0;
      rx_sh  <= '0;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
      if (!rx_act) begin
        if (baud_tick && !rx_s) begin
          rx_act <= 1'b1;
          rx_cnt <= '0;
          rx_bit <= '0;
        end
      end else if (baud_tick) begin
        rx_cnt <= rx_cnt + 1'b1;
        if (rx_cnt == C_S0 || rx_cnt == C_S1) rx_smp <= {rx_s, rx_smp[1]};
        if (rx_cnt == C_S2) begin
          if (rx_bit == 4'd0 && vote) rx_act <= 1'b0;
          else if (rx_bit == LASTB)   rx_act <= 1'b0;
          else if (rx_bit != 4'd0)    rx_sh  <= {vote, rx_sh[8:1]};
        end
        if (rx_cnt == C_LAST) begin
          rx_cnt <= '0;
          rx_bit <= rx_bit + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rbuf       <= '0;
      rx_ninth   <= 1'b0;
      rx_ready   <= 1'b0;
      addr_match <= 1'b0;
    end else begin
      if (clr_rx_ready) rx_ready <= 1'b0;
      if (accept) begin
        rbuf     <= rx_sh[7:0];
        rx_ninth <= rx_sh[8];
        rx_ready <= 1'b1;
      end
      if (stop_ok && mp_mode && rx_sh[8]) addr_match <= addr_hit;
    end
  end

  assert_start_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd);
  assert_busy_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && wr_data && !baud_tick) |=> $stable(tx_sh));
  assert_done_with_frame_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> $fell(tx_busy));
  assert_latch_needs_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rbuf) |-> $past(stop_ok));
  assert_ready_needs_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(stop_ok));
  assert_data_gated_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ok && mp_mode && !rx_sh[8] && !addr_match && !clr_rx_ready) |=> $stable(rbuf) && $stable(rx_ready));
  assert_zero_mask_selects_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ok && mp_mode && rx_sh[8] && cmp_mask == 8'h00) |=> addr_match);
endmodule

// File: tb/sim_uart_maddr.sv
module sim_uart_maddr;
  localparam int CLK_NS = 10;
  localparam int BITC = 16;
  localparam int FRAMEC = 11 * BITC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic baud_tick = 1'b1;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic tx_ninth = 1'b0, mp_mode = 1'b0, clr_tx_done = 1'b0, clr_rx_ready = 1'b0;
  logic loop = 1'b1, rx_drv = 1'b1;
  logic txd, tx_done, rx_ready, rx_ninth, addr_match;
  wire rxd = loop ? txd : rx_drv;

  uart_maddr u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_ninth(tx_ninth), .mp_mode(mp_mode), .clr_tx_done(clr_tx_done),
    .clr_rx_ready(clr_rx_ready), .rxd(rxd), .txd(txd), .tx_done(tx_done),
    .rx_ready(rx_ready), .rx_ninth(rx_ninth), .addr_match(addr_match)
  );

  always #(CLK_NS/2) clk = ~clk;

  int cyc = 0, checks = 0, errors = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // reference model state
  bit m_on = 0;
  int m_start = 0;
  logic [10:0] m_frame;
  logic [7:0] e_buf = 8'h00, e_addr = 8'h00, e_mask = 8'h00;
  bit e_rdy = 0, e_nin = 0, e_sel = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && m_on) begin
      int d;
      d = cyc - m_start;
      if (d < FRAMEC) chk(txd == m_frame[d / BITC], "R3 txd bit", txd, m_frame[d / BITC]);
      else begin
        chk(tx_done == 1'b1, "R5 tx_done at stop end", tx_done, 1);
        m_on = 0;
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 2'd0 && !m_on) begin
      m_frame = {1'b1, tx_ninth, d, 1'b0};
      m_start = cyc;
      m_on = 1;
    end
    if (a == 2'd1) e_addr = d;
    if (a == 2'd2) e_mask = d;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    reg_addr = a;
    #1 chk(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  task automatic model_rx(input bit nin, input logic [7:0] b);
    bit hit;
    hit = ((b ^ e_addr) & e_mask) == 8'h00;
    if (!mp_mode || (nin ? hit : e_sel)) begin
      e_buf = b; e_nin = nin; e_rdy = 1;
    end
    if (mp_mode && nin) e_sel = hit;
  endtask

  task automatic check_rx(input string req);
    rd(2'd0, e_buf, req);
    chk(rx_ready == e_rdy, req, rx_ready, e_rdy);
    chk(rx_ninth == e_nin, req, rx_ninth, e_nin);
    chk(addr_match == e_sel, req, addr_match, e_sel);
  endtask

  task automatic clear_flags;
    @(negedge clk);
    clr_tx_done = 1'b1; clr_rx_ready = 1'b1;
    @(negedge clk);
    clr_tx_done = 1'b0; clr_rx_ready = 1'b0;
    e_rdy = 0;
    #1 chk(tx_done == 1'b0 && rx_ready == 1'b0, "R5 R9 flags cleared", {tx_done, rx_ready}, 0);
  endtask

  task automatic send(input bit nin, input logic [7:0] b, input string req);
    tx_ninth = nin;
    wr(2'd0, b);
    wait (!m_on);
    model_rx(nin, b);
    check_rx(req);
    clear_flags();
  endtask

  task automatic drive(input bit nin, input logic [7:0] b, input bit stopv, input bit flip);
    logic [10:0] f;
    f = {stopv, nin, b, 1'b0};
    loop = 1'b0;
    for (int i = 0; i < 11; i++)
      for (int j = 0; j < BITC; j++) begin
        @(negedge clk);
        rx_drv = (flip && i >= 1 && i <= 8 && j == 8) ? ~f[i] : f[i];
      end
    @(negedge clk);
    rx_drv = 1'b1;
    repeat (40) @(negedge clk);
    if (stopv) model_rx(nin, b);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(2'd0, 8'h00, "R1 data reset");
    rd(2'd1, 8'h00, "R1 addr reset");
    rd(2'd2, 8'h00, "R1 mask reset");
    chk(txd == 1'b1, "R1 txd idle", txd, 1);
    chk({tx_done, rx_ready, rx_ninth, addr_match} == 4'b0, "R1 flags reset",
        {tx_done, rx_ready, rx_ninth, addr_match}, 0);

    // R10 normal mode accepts all frames, R9 ninth bit reported
    send(0, 8'hA5, "R10 data frame normal mode");
    send(1, 8'h3C, "R10 R9 ninth=1 frame normal mode");

    // R4 write while busy ignored
    tx_ninth = 0;
    wr(2'd0, 8'h81);
    repeat (50) @(negedge clk);
    wr(2'd0, 8'h7E);
    wait (!m_on);
    model_rx(0, 8'h81);
    check_rx("R4 second write ignored");
    // R5 tx_done held until cleared
    repeat (5) @(negedge clk);
    chk(tx_done == 1'b1, "R5 tx_done held", tx_done, 1);
    clear_flags();

    // R12 unselected data discarded, R13 zero mask matches
    mp_mode = 1'b1;
    send(0, 8'h44, "R12 data dropped when unselected");
    send(1, 8'hC3, "R13 zero mask matches any address");

    // R2 register map
    wr(2'd1, 8'h5A);
    wr(2'd2, 8'hF0);
    rd(2'd1, 8'h5A, "R2 address readback");
    rd(2'd2, 8'hF0, "R2 mask readback");
    rd(2'd3, 8'h00, "R2 unused address");
    rd(2'd0, e_buf, "R2 data read returns latch");

    // R11 masked compare
    send(1, 8'h53, "R11 masked match");
    send(0, 8'h11, "R12 data accepted when selected");
    send(1, 8'h3A, "R11 masked mismatch");
    send(0, 8'h22, "R12 data dropped after mismatch");
    wr(2'd2, 8'hFF);
    send(1, 8'h5B, "R11 full mask mismatch");
    send(1, 8'h5A, "R11 full mask match");

    // R6 majority vote corrects one flipped sample
    drive(0, 8'h96, 1, 1);
    check_rx("R6 majority vote");
    clear_flags();

    // R8 bad stop bit
    drive(0, 8'h0F, 0, 0);
    check_rx("R8 bad stop keeps latch");

    // R7 start glitch then recovery
    loop = 1'b0;
    @(negedge clk); rx_drv = 1'b0;
    repeat (4) @(negedge clk);
    rx_drv = 1'b1;
    repeat (60) @(negedge clk);
    check_rx("R7 short start pulse rejected");
    drive(1, 8'h5A, 1, 0);
    check_rx("R7 receiver recovers after glitch");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule